// File: doc/BRIEF.md
# Streaming Tap-Addressed Frame Reorderer

This block accepts a stream of samples in natural index order, at most one per clock, and returns each frame in a permuted order at the same rate. There is no double buffer and no load or drain phase. Every accepted sample is pushed into one cascaded shift chain. Each accepted cycle, one tap of that chain is chosen as the output. The tap index comes from a small frame-phase counter through a constant lookup table. The table holds, for each phase, how many samples back the wanted sample sits.

A static parameter selects the permutation. Mode 0 reorders 16-sample frames into 4-bit bit-reversed index order. It needs a chain of two 16-deep segments. Mode 1 reverses 8-sample frames and needs one 16-deep segment.

Cycles with input valid low are gaps. During a gap the chain, the phase counter and the output all freeze, so a gap leaves the reordered sequence intact. The sample width is a parameter, and all bits of a sample are read through the same tap.

Top module: `tap_reorder`

## Requirements
- R1: While reset is high, and in the first cycle after reset, out_valid is 0 and out_data is 0. Reset is synchronous and active high.
- R2: After reset, out_valid stays 0 until the priming latency has passed. The first valid output follows the accepted input with index L, where L is 9 in mode 0 and 7 in mode 1, counting inputs from 0.
- R3: Once primed, each clock edge that accepts an input (in_valid 1) gives out_valid 1 in the following cycle.
- R4: A cycle with in_valid 0 gives out_valid 0 in the next cycle, and out_data keeps its value. The gap shifts neither the frame order nor the data pairing.
- R5: In mode 0 (MODE=0), output number m after reset, counted from 0, carries input sample 16*(m/16) + rev4(m%16). Within a frame the source indices run 0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15.
- R6: In mode 1 (MODE=1), output number m after reset carries input sample 8*(m/8) + 7 - (m%8). Each frame comes out reversed.
- R7: Every bit of a DATA_W-wide sample follows the same permutation, with random values across the full width.
- R8: Frames stream back to back with no stall. After n continuous inputs from reset, exactly n - L outputs have been flagged valid.
- R9: A reset asserted mid-stream discards the stored frames, restarts priming and restarts frame phase at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DATA_W | Input sample, natural order |
| out_valid | output | 1 | Reordered sample present |
| out_data | output | DATA_W | Reordered sample |

## Verification
Two functions can land in the same accepted cycle: writing a new sample into the chain, and reading that same sample out through the zero-delay tap. This happens in mode 1 at the last slot of each frame, and in mode 0 wherever the table's delay is small. The bench drives long continuous runs, with gaps placed just before and just after frame boundaries, so the bypass tap and the shifted chain are read in the same cycles as writes. The result is judged by matching every output against the software permutation of the recorded input history.

// File: rtl/tap_reorder_pkg.sv
package tap_reorder_pkg;

   localparam int MODE_BITREV16 = 0;
   localparam int MODE_MIRROR8  = 1;

   function automatic int frame_len(input int mode);
      return (mode == MODE_BITREV16) ? 16 : 8;
   endfunction

   // source index within a frame for output slot j
   function automatic int slot_src(input int mode, input int j);
      if (mode == MODE_BITREV16)
         return ((j & 1) << 3) | ((j & 2) << 1) | ((j & 4) >> 1) | ((j & 8) >> 3);
      return 7 - j;
   endfunction

   // smallest latency keeping every read delay non-negative
   function automatic int base_latency(input int mode);
      int lat = 0;
      for (int j = 0; j < frame_len(mode); j++)
         if (slot_src(mode, j) - j > lat) lat = slot_src(mode, j) - j;
      return lat;
   endfunction

   // read delay used when the phase counter equals c
   function automatic int tap_delay(input int mode, input int c);
      int n = frame_len(mode);
      int l = base_latency(mode);
      int j = (c + n - (l % n)) % n;
      return l + j - slot_src(mode, j);
   endfunction

   function automatic int max_delay(input int mode);
      int m = 0;
      for (int c = 0; c < frame_len(mode); c++)
         if (tap_delay(mode, c) > m) m = tap_delay(mode, c);
      return m;
   endfunction

endpackage

// File: rtl/tap_chain_seg.sv
module tap_chain_seg #(
   parameter int W     = 16,
   parameter int DEPTH = 16
) (
   input  logic                      clk,
   input  logic                      en,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   taps
);
   initial assert (DEPTH >= 2 && W >= 1) else $error("tap_chain_seg: bad geometry");

   always_ff @(posedge clk) begin
      if (en) taps <= {taps[DEPTH-2:0], din};
   end
endmodule

// File: rtl/tap_phase_gen.sv
module tap_phase_gen
   import tap_reorder_pkg::*;
#(
   parameter int MODE  = MODE_BITREV16,
   parameter int TAPS  = 33,
   parameter int TAP_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [TAP_W-1:0] tap
);
   localparam int N     = frame_len(MODE);
   localparam int CNT_W = $clog2(N);

   logic [CNT_W-1:0] cnt;
   logic [TAP_W-1:0] rom [N];

   for (genvar gi = 0; gi < N; gi++) begin : g_rom
      assign rom[gi] = TAP_W'(tap_delay(MODE, gi));
   end

   always_ff @(posedge clk) begin
      if (rst)                          cnt <= '0;
      else if (en && cnt == CNT_W'(N-1)) cnt <= '0;
      else if (en)                      cnt <= cnt + 1'b1;
   end

   assign tap = rom[cnt];

   // R8: phase wraps straight into the next frame
   a_r8_phase_wrap: assert property (@(posedge clk) disable iff (rst)
      (en && cnt == CNT_W'(N-1)) |=> (cnt == '0));
   // R5: every addressed tap exists in the chain
   a_r5_tap_in_chain: assert property (@(posedge clk) disable iff (rst)
      int'(tap) < TAPS);
endmodule

// File: rtl/tap_select.sv
module tap_select #(
   parameter int W     = 16,
   parameter int TAPS  = 33,
   parameter int TAP_W = 6
) (
   input  logic [TAPS-1:0][W-1:0] taps,
   input  logic [TAP_W-1:0]       tap,
   output logic [W-1:0]           sel
);
   always_comb begin
      sel = '0;
      if (int'(tap) < TAPS) sel = taps[tap];
   end
endmodule

// File: rtl/tap_reorder.sv
module tap_reorder
   import tap_reorder_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int MODE      = MODE_BITREV16,
   parameter int SEG_DEPTH = 16,
   parameter int NUM_SEG   = (MODE == MODE_BITREV16) ? 2 : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int CHAIN  = NUM_SEG * SEG_DEPTH;
   localparam int TAPS   = CHAIN + 1;
   localparam int TAP_W  = $clog2(TAPS);
   localparam int LAT    = base_latency(MODE);
   localparam int FILL_W = $clog2(LAT + 2);

   initial begin
      assert (MODE == MODE_BITREV16 || MODE == MODE_MIRROR8) else $error("tap_reorder: MODE");
      assert (DATA_W >= 1) else $error("tap_reorder: DATA_W");
      assert (max_delay(MODE) <= CHAIN) else $error("tap_reorder: chain too short");
   end

   logic [NUM_SEG-1:0][SEG_DEPTH-1:0][DATA_W-1:0] seg_taps;
   logic [TAPS-1:0][DATA_W-1:0]                   all_taps;
   logic [TAP_W-1:0]                              tap;
   logic [DATA_W-1:0]                             picked;
   logic [FILL_W-1:0]                             fill_q;
   logic                                          primed;

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic [DATA_W-1:0] seg_in;
      if (s == 0) begin : g_head
         assign seg_in = in_data;
      end else begin : g_link
         assign seg_in = seg_taps[s-1][SEG_DEPTH-1];
      end
      tap_chain_seg #(.W(DATA_W), .DEPTH(SEG_DEPTH)) u_seg (
         .clk (clk), .en (in_valid), .din (seg_in), .taps (seg_taps[s]));
   end

   // tap 0 is the sample arriving now, tap d is d accepted samples back
   assign all_taps = {seg_taps, in_data};

   tap_phase_gen #(.MODE(MODE), .TAPS(TAPS), .TAP_W(TAP_W)) u_phase (
      .clk (clk), .rst (rst), .en (in_valid), .tap (tap));

   tap_select #(.W(DATA_W), .TAPS(TAPS), .TAP_W(TAP_W)) u_sel (
      .taps (all_taps), .tap (tap), .sel (picked));

   assign primed = (fill_q == FILL_W'(LAT));

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid && primed;
         if (in_valid && !primed) fill_q <= fill_q + 1'b1;
         if (in_valid && primed)  out_data <= picked;
      end
   end

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_data == '0));
   a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));
   a_r4_gap_holds: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_data)));
endmodule

// File: tb/tap_reorder_test.sv
module tap_reorder_test;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         ov_b, ov_m;
   logic [W-1:0] od_b, od_m;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int           k;
   logic [W-1:0] hist [4096];
   int           mb, mm;
   logic [W-1:0] last_b, last_m;

   always #2.5 clk = ~clk;

   tap_reorder #(.DATA_W(W), .MODE(0)) uut (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
      .out_valid (ov_b), .out_data (od_b));

   tap_reorder #(.DATA_W(W), .MODE(1)) uut_mir (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
      .out_valid (ov_m), .out_data (od_m));

   function automatic int src(input int mode, input int j);
      if (mode == 0) return {j[0], j[1], j[2], j[3]};
      return 7 - j;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic judge(input int mode, input bit v, input int kb, input logic ov,
                        input logic [W-1:0] od, inout int m, inout logic [W-1:0] last,
                        input string dtag);
      int lat = (mode == 0) ? 9 : 7;
      int n   = (mode == 0) ? 16 : 8;
      bit ev  = v && (kb >= lat);
      chk(ov == ev, !v ? "R4" : (kb < lat ? "R2" : "R3"), ov, ev);
      if (ev) begin
         logic [W-1:0] e = hist[(m / n) * n + src(mode, m % n)];
         chk(od == e, dtag, od, e);
         m++;
         last = od;
      end else begin
         chk(od == last, "R4", od, last);
      end
   endtask

   task automatic cyc(input bit v, input logic [W-1:0] d, input string tb_tag, input string tm_tag);
      int kb;
      in_valid = v;
      in_data  = d;
      @(posedge clk);
      kb = k;
      if (v) begin hist[k] = d; k++; end
      @(negedge clk);
      judge(0, v, kb, ov_b, od_b, mb, last_b, tb_tag);
      judge(1, v, kb, ov_m, od_m, mm, last_m, tm_tag);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      in_valid = 1'b1;
      in_data = 12'hABC;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(!ov_b && od_b == '0, tag, {ov_b, od_b}, 0);
      chk(!ov_m && od_m == '0, tag, {ov_m, od_m}, 0);
      rst = 1'b0;
      in_valid = 1'b0;
      k = 0; mb = 0; mm = 0; last_b = '0; last_m = '0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      do_reset("R1");
      // R5 R6 R8: continuous ramp frames
      for (int i = 0; i < 64; i++) cyc(1'b1, W'(i), "R5", "R6");
      chk(mb == 55, "R8", mb, 55);
      chk(mm == 57, "R8", mm, 57);
      // R4: gaps at and around frame boundaries
      for (int i = 0; i < 80; i++)
         cyc(($urandom % 3) != 0 || (i % 8) == 3 ? 1'b1 : 1'b0, W'(i + 100), "R5", "R6");
      for (int i = 0; i < 5; i++) cyc(1'b0, '0, "R4", "R4");
      // R7: full-width random data, occasional gaps
      for (int i = 0; i < 300; i++)
         cyc(($urandom % 5) != 0, W'($urandom), "R7", "R7");
      // R9: reset mid-stream, priming and phase restart
      for (int i = 0; i < 3; i++) cyc(1'b1, W'($urandom), "R7", "R7");
      do_reset("R9");
      cyc(1'b0, '0, "R9", "R9");
      for (int i = 0; i < 48; i++) cyc(1'b1, W'(12'hF00 | i), "R9", "R9");
      chk(mb == 39, "R9", mb, 39);
      chk(mm == 41, "R9", mm, 41);
      // R2: gap during priming does not shorten it
      do_reset("R1");
      for (int i = 0; i < 6; i++) cyc(1'b1, W'(i + 7), "R2", "R2");
      cyc(1'b0, '0, "R2", "R2");
      for (int i = 0; i < 40; i++) cyc(1'b1, W'($urandom), "R5", "R6");
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule